// File: doc/BRIEF.md
# Diagnostic Status Generator for a Multi-Channel Low-Side Switch

This block drives one status bit per switch channel. The bit is meant for a host that watches it through an open-drain line. With no fault on a channel, the bit reports whether that channel is commanded on, where the command is the global enable ANDed with the channel's control input. When the block sees a problem on a channel, it inverts that channel's bit. The problems it watches are a set protection latch, an open load while the channel is on, and a confirmed open load while the channel is off. Analog sensing stays outside the block: the comparators hand it single-bit flags, and a free-running 1 µs tick paces every timer.

The bit is shaped so that a host can read it without tracking each PWM edge. After the command drops, the "on" level is held for a long off-hold time, so short PWM off-phases leave the bit steady. The raw off-state open-load flag must hold for a filter time before the block accepts it. Once an inversion has been reported, it is stretched for a minimum time after its cause goes away. While standby is asserted, every status bit is forced high. After reset or after leaving standby, the bits are forced high for a wake-up mask time, because the analog side is not yet settled then.

Top module: `diag_status_gen`

## Requirements
- R1: With no error on a channel and once the off-hold has expired, the channel's status is 1 when the command (enable AND control input) is 1 and 0 when it is 0. With enable low, the on-state open-load flag has no effect.
- R2: After a channel's command falls, its status keeps the on level for OFF_HOLD_TICKS ticks. An off-phase shorter than that leaves the status steadily 1.
- R3: An off-phase longer than OFF_HOLD_TICKS ticks brings the status to 0, so the status follows the command.
- R4: An on-state open-load flag while the channel is commanded on inverts the status to 0 within a few cycles.
- R5: While the command is 0, the off-state open-load flag inverts the status (to 1) only after it has stayed high for OL_FILTER_TICKS consecutive ticks. Shorter pulses have no effect, and the flag is ignored while the command is 1.
- R6: While the channel's protection fault input is high, the status stays inverted: 0 when commanded on, 1 when commanded off.
- R7: After every error cause on a channel clears, the inversion persists for FAIL_EXT_TICKS more ticks.
- R8: While standby is high, all status bits are 1 whatever the other inputs are, and channel timers are cleared.
- R9: After reset release and after standby falls, all status bits stay 1 for WAKE_MASK_TICKS ticks.
- R10: Every timer advances only in cycles where the tick input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle timebase strobe, nominally every 1 µs |
| standby | input | 1 | High forces standby: all status high, timers cleared |
| enable | input | 1 | Global enable for all channel commands |
| ctl_in | input | NCH | Per-channel control inputs |
| prot_fault | input | NCH | Per-channel latched protection fault (overload or overtemperature) |
| ol_on_raw | input | NCH | Per-channel low-load-current flag, used while commanded on |
| ol_off_raw | input | NCH | Per-channel low-drain-voltage flag, used while commanded off (unfiltered) |
| status | output | NCH | Per-channel status bit, registered |

## Verification
The hardest case to reach is one where two long timers overlap on a channel. For example, the off-hold is still counting while a failure extension runs down, or a short PWM off-phase falls inside the filter window. At the ports, such a case only shows as an inversion that lasts or does not last. The stimulus settles every channel for longer than the sum of all timer lengths between table vectors, so that each vector has an unambiguous steady-state result. Directed sequences then probe just before and just after each timer boundary, including one run with the tick slowed to a quarter rate so that timer progress can be told apart from cycle count.

// File: rtl/diag_status_pkg.sv
package diag_status_pkg;

  // Status encoding: normal level is the (held) on level, inverted on error.
  function automatic logic status_code(logic on_level, logic err_active);
    return on_level ^ err_active;
  endfunction

  // Any error cause currently present on a channel.
  function automatic logic chan_error(logic cmd, logic fault, logic ol_on, logic ol_filt);
    return fault | (cmd & ol_on) | ol_filt;
  endfunction

  // Level the status takes during standby and wake-up masking.
  localparam logic FORCED_LEVEL = 1'b1;

endpackage

// File: rtl/dsg_on_hold.sv
module dsg_on_hold #(
  parameter int HOLD_TICKS = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic cmd,
  output logic on_lvl
);
  localparam int W = $clog2(HOLD_TICKS + 1);
  localparam logic [W-1:0] LAST = W'(HOLD_TICKS - 1);

  logic [W-1:0] cnt;
  logic         on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      on_q <= 1'b0;
      cnt  <= '0;
    end else if (cmd) begin
      on_q <= 1'b1;
      cnt  <= '0;
    end else if (on_q && tick) begin
      if (cnt == LAST) begin
        on_q <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign on_lvl = on_q;
endmodule

// File: rtl/dsg_persist_filter.sv
module dsg_persist_filter #(
  parameter int TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic arm,
  output logic passed
);
  localparam int W = $clog2(TICKS + 1);
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] cnt;
  logic         pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      cnt    <= '0;
    end else if (clr || !arm) begin
      pass_q <= 1'b0;
      cnt    <= '0;
    end else if (tick && !pass_q) begin
      if (cnt == LAST) pass_q <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end

  assign passed = pass_q;
endmodule

// File: rtl/dsg_fail_stretch.sv
module dsg_fail_stretch #(
  parameter int TICKS = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic err_now,
  output logic ext_act
);
  localparam int W = $clog2(TICKS + 1);
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] cnt;
  logic         act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt   <= '0;
    end else if (clr) begin
      act_q <= 1'b0;
      cnt   <= '0;
    end else if (err_now) begin
      act_q <= 1'b1;
      cnt   <= '0;
    end else if (act_q && tick) begin
      if (cnt == LAST) begin
        act_q <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ext_act = act_q;
endmodule

// File: rtl/dsg_wake_mask.sv
module dsg_wake_mask #(
  parameter int TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic tick,
  output logic masked
);
  localparam int W = $clog2(TICKS + 1);
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] cnt;
  logic         mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      cnt    <= '0;
    end else if (standby) begin
      mask_q <= 1'b1;
      cnt    <= '0;
    end else if (mask_q && tick) begin
      if (cnt == LAST) begin
        mask_q <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign masked = mask_q;
endmodule

// File: rtl/diag_status_gen.sv
module diag_status_gen
  import diag_status_pkg::*;
#(
  parameter int NCH             = 4,
  parameter int OFF_HOLD_TICKS  = 1200,
  parameter int OL_FILTER_TICKS = 50,
  parameter int FAIL_EXT_TICKS  = 1200,
  parameter int WAKE_MASK_TICKS = 2000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_1us,
  input  logic           standby,
  input  logic           enable,
  input  logic [NCH-1:0] ctl_in,
  input  logic [NCH-1:0] prot_fault,
  input  logic [NCH-1:0] ol_on_raw,
  input  logic [NCH-1:0] ol_off_raw,
  output logic [NCH-1:0] status
);

  // Named internal events, visible to the bound checker.
  logic [NCH-1:0] cmd;
  logic [NCH-1:0] on_lvl;
  logic [NCH-1:0] ol_filt;
  logic [NCH-1:0] err_now;
  logic [NCH-1:0] ext_act;
  logic [NCH-1:0] err_hold;
  logic           wake_mask;
  logic [NCH-1:0] status_q;

  dsg_wake_mask #(.TICKS(WAKE_MASK_TICKS)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .standby (standby),
    .tick    (tick_1us),
    .masked  (wake_mask)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign cmd[ch] = enable & ctl_in[ch];

    dsg_on_hold #(.HOLD_TICKS(OFF_HOLD_TICKS)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (standby),
      .tick   (tick_1us),
      .cmd    (cmd[ch]),
      .on_lvl (on_lvl[ch])
    );

    dsg_persist_filter #(.TICKS(OL_FILTER_TICKS)) u_olf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (standby),
      .tick   (tick_1us),
      .arm    (ol_off_raw[ch] & ~cmd[ch]),
      .passed (ol_filt[ch])
    );

    assign err_now[ch] = chan_error(cmd[ch], prot_fault[ch], ol_on_raw[ch], ol_filt[ch]);

    dsg_fail_stretch #(.TICKS(FAIL_EXT_TICKS)) u_ext (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (standby),
      .tick    (tick_1us),
      .err_now (err_now[ch]),
      .ext_act (ext_act[ch])
    );

    assign err_hold[ch] = err_now[ch] | ext_act[ch];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      status_q[ch] <= FORCED_LEVEL;
      else if (standby || wake_mask)   status_q[ch] <= FORCED_LEVEL;
      else                             status_q[ch] <= status_code(on_lvl[ch], err_hold[ch]);
    end
  end

  assign status = status_q;

endmodule

// File: rtl/diag_status_gen_chk.sv
module diag_status_gen_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           standby,
  input logic [NCH-1:0] prot_fault,
  input logic [NCH-1:0] ol_off_raw,
  input logic [NCH-1:0] status,
  input logic [NCH-1:0] cmd,
  input logic [NCH-1:0] on_lvl,
  input logic [NCH-1:0] ol_filt,
  input logic [NCH-1:0] err_now,
  input logic [NCH-1:0] ext_act,
  input logic           wake_mask
);

  p_standby_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (&status));

  p_wake_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) |=> (&status));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_fault_inverts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby && !$past(standby) && !wake_mask && prot_fault[i] && cmd[i] && $past(cmd[i]))
      |=> !status[i]);

    p_hold_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cmd[i]) && !standby && !$past(standby)) |=> on_lvl[i]);

    p_filter_needs_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ol_filt[i]) |-> $past(ol_off_raw[i] && !cmd[i]));

    p_stretch_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(err_now[i]) && !$past(standby)) |-> ext_act[i]);
  end

endmodule

bind diag_status_gen diag_status_gen_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .standby    (standby),
  .prot_fault (prot_fault),
  .ol_off_raw (ol_off_raw),
  .status     (status),
  .cmd        (cmd),
  .on_lvl     (on_lvl),
  .ol_filt    (ol_filt),
  .err_now    (err_now),
  .ext_act    (ext_act),
  .wake_mask  (wake_mask)
);

// File: tb/test_diag_status_gen.sv
`timescale 1ns/1ps
module test_diag_status_gen;
  localparam int NCH    = 4;
  localparam int SETTLE = 2700;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick_1us;
  logic           standby = 1'b0;
  logic           enable = 1'b0;
  logic [NCH-1:0] ctl_in = '0;
  logic [NCH-1:0] prot_fault = '0;
  logic [NCH-1:0] ol_on_raw = '0;
  logic [NCH-1:0] ol_off_raw = '0;
  logic [NCH-1:0] status;

  logic       slow_tick = 1'b0;
  logic [1:0] div = '0;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) div <= div + 2'd1;
  assign tick_1us = !slow_tick || (div == 2'd0);

  diag_status_gen i_diag_status_gen (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .standby(standby),
    .enable(enable), .ctl_in(ctl_in), .prot_fault(prot_fault),
    .ol_on_raw(ol_on_raw), .ol_off_raw(ol_off_raw), .status(status)
  );

  // Vector fields: {enable, ctl[3:0], fault[3:0], ol_on[3:0], ol_off[3:0]}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 4'hF, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'h5, 4'h0, 4'h0, 4'h0},
    {1'b0, 4'hF, 4'h0, 4'hF, 4'h0},
    {1'b1, 4'h3, 4'h0, 4'h1, 4'h0},
    {1'b1, 4'h0, 4'h0, 4'h0, 4'hA},
    {1'b1, 4'hF, 4'h0, 4'h0, 4'hF},
    {1'b1, 4'hC, 4'h6, 4'h0, 4'h0},
    {1'b1, 4'h6, 4'h0, 4'h3, 4'h9}
  };

  // Steady-state expectation restated from the requirements.
  function automatic logic [3:0] steady(logic [16:0] v);
    logic [3:0] on  = v[16] ? v[15:12] : 4'h0;
    logic [3:0] bad = v[11:8] | (on & v[7:4]) | (~on & v[3:0]);
    return on ^ bad;
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(logic [3:0] got, logic [3:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: status=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    wait_n(5);
    chk(status, 4'hF, "R9 reset level");
    rst_n = 1'b1;
    enable = 1'b1;
    wait_n(20);
    chk(status, 4'hF, "R9 mask after reset");
    wait_n(1880);
    chk(status, 4'hF, "R9 mask near end");
    wait_n(200);
    chk(status, 4'h0, "R9 mask expired, R1 idle low");

    // Steady-state table: R1 R4 R5 R6
    foreach (VEC[k]) begin
      enable     = VEC[k][16];
      ctl_in     = VEC[k][15:12];
      prot_fault = VEC[k][11:8];
      ol_on_raw  = VEC[k][7:4];
      ol_off_raw = VEC[k][3:0];
      wait_n(SETTLE);
      chk(status, steady(VEC[k]), $sformatf("R1/R4/R5/R6 vector %0d", k));
    end
    enable = 1'b1; ctl_in = '0; prot_fault = '0; ol_on_raw = '0; ol_off_raw = '0;
    wait_n(SETTLE);
    chk(status, 4'h0, "R1 all off");

    // R2: PWM with short off-phases keeps status steady
    ctl_in[0] = 1'b1;
    wait_n(100);
    for (int p = 0; p < 4; p++) begin
      ctl_in[0] = 1'b0;
      wait_n(590);
      chk(status, 4'h1, "R2 short off-phase held");
      wait_n(10);
      ctl_in[0] = 1'b1;
      wait_n(200);
    end

    // R3: long off-phase lets status follow
    ctl_in[0] = 1'b0;
    wait_n(1190);
    chk(status, 4'h1, "R3 before hold expiry");
    wait_n(40);
    chk(status, 4'h0, "R3 after hold expiry");

    // R5: short off-state open-load pulse rejected
    ol_off_raw[1] = 1'b1;
    wait_n(30);
    chk(status, 4'h0, "R5 short pulse filtered");
    ol_off_raw[1] = 1'b0;
    wait_n(5);
    chk(status, 4'h0, "R5 after short pulse");
    ol_off_raw[1] = 1'b1;
    wait_n(70);
    chk(status, 4'h2, "R5 persistent open load accepted");
    ol_off_raw[1] = 1'b0;
    // R7: stretched after the cause clears
    wait_n(1100);
    chk(status, 4'h2, "R7 extension still active");
    wait_n(200);
    chk(status, 4'h0, "R7 extension expired");

    // R4 and R7 for on-state open load
    ctl_in[2] = 1'b1;
    wait_n(1300);
    chk(status, 4'h4, "R1 channel on");
    ol_on_raw[2] = 1'b1;
    wait_n(5);
    chk(status, 4'h0, "R4 on-state open load inverts");
    ol_on_raw[2] = 1'b0;
    wait_n(1100);
    chk(status, 4'h0, "R7 on-state extension");
    wait_n(200);
    chk(status, 4'h4, "R7 on-state recovered");
    ctl_in[2] = 1'b0;
    wait_n(1300);

    // R6: protection latch holds the inversion
    ctl_in[3] = 1'b1;
    wait_n(50);
    prot_fault[3] = 1'b1;
    wait_n(5);
    chk(status, 4'h0, "R6 fault inverts on channel");
    wait_n(3000);
    chk(status, 4'h0, "R6 fault still latched");
    prot_fault[3] = 1'b0;
    wait_n(1300);
    chk(status, 4'h8, "R6 fault cleared");
    ctl_in[3] = 1'b0;
    wait_n(1300);
    chk(status, 4'h0, "R1 back to idle");

    // R10: quarter-rate tick stretches the hold
    slow_tick = 1'b1;
    ctl_in[0] = 1'b1;
    wait_n(50);
    ctl_in[0] = 1'b0;
    wait_n(2000);
    chk(status, 4'h1, "R10 hold counts ticks, not cycles");
    wait_n(3000);
    chk(status, 4'h0, "R10 hold expired at tick rate");
    slow_tick = 1'b0;

    // R8: standby forces high and ignores inputs
    standby = 1'b1;
    wait_n(3);
    chk(status, 4'hF, "R8 standby forced high");
    ctl_in = 4'hF; prot_fault = 4'h3;
    wait_n(20);
    chk(status, 4'hF, "R8 inputs ignored in standby");
    ctl_in = '0; prot_fault = '0;
    wait_n(5);
    standby = 1'b0;
    wait_n(1900);
    chk(status, 4'hF, "R9 mask after standby exit");
    wait_n(200);
    chk(status, 4'h0, "R9 mask expired after standby");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule